// File: doc/BRIEF.md
# Completion Ordering Holding FIFO

This block parks inbound completion packets until the ordering rule between posted writes and completions lets each one go. Each packet is reduced to a header word and a payload-beat count. As a completion is stored, the block takes a snapshot of a running count of posted writes accepted so far. A second running count tracks posted writes that have drained. The head packet is offered downstream only once the drained count has reached its snapshot. That proves every posted write that came in ahead of it has left.

A runtime configuration word can switch the gate off, for systems where the completion and posted streams are independent. Packets always leave in arrival order. The gate can stall only the head entry. The depth is counted in packets, 256 by default. The block exports its occupancy and a full flag so that upstream logic can throttle. A completion that arrives while the store is full is discarded and raises a sticky overflow flag.

Top module: `cpl_ord_fifo`

## Requirements
- R1: After reset, occupancy_o is 0 and full_o, overflow_o and out_valid_o are all 0.
- R2: Completions leave in arrival order. out_hdr_o and out_beats_o repeat the stored cpl_hdr_i and cpl_beats_i unchanged. A packet leaves in a cycle where out_valid_o and out_ready_i are both 1.
- R3: While the ordering gate is active, a stored completion is not offered until the number of drained posted writes reaches the number accepted before it. A posted write accepted in the same cycle as the completion counts as before it. pw_accept_i and pw_drain_i each count one write per cycle they are 1.
- R4: Posted writes accepted after a completion was stored do not delay that completion.
- R5: When bit 30 of cfg_word_i is 1, the head completion is offered without regard to posted traffic. The other 31 bits of cfg_word_i have no effect.
- R6: occupancy_o gives the number of stored packets. full_o is 1 exactly when occupancy_o equals DEPTH (256).
- R7: A completion presented while full_o is 1 is dropped and leaves the stored contents unchanged. This holds even in a cycle where a packet leaves. The drop sets overflow_o, which stays 1 until reset.
- R8: Only the head entry is gated. A later entry never leaves ahead of it, even if that later entry's own condition is met.
- R9: The gate comparison is wrap-safe. It stays correct when the 16-bit posted counters wrap past 65535, provided fewer than 32768 posted writes are outstanding.
- R10: While the store is non-empty and no packet leaves, out_hdr_o and out_beats_o hold their values. This holds even when a new completion is stored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid_i | input | 1 | Completion presented for storage this cycle |
| cpl_hdr_i | input | HDR_W (32) | Completion header word |
| cpl_beats_i | input | BEATS_W (8) | Completion payload-beat count |
| pw_accept_i | input | 1 | One posted write accepted this cycle |
| pw_drain_i | input | 1 | One posted write drained this cycle |
| cfg_word_i | input | 32 | Configuration word; bit 30 disables the ordering gate |
| out_valid_o | output | 1 | Head completion offered |
| out_ready_i | input | 1 | Downstream takes the offered completion |
| out_hdr_o | output | HDR_W (32) | Header of the head completion |
| out_beats_o | output | BEATS_W (8) | Beat count of the head completion |
| occupancy_o | output | OCC_W (9) | Number of stored completions |
| full_o | output | 1 | Store holds DEPTH packets |
| overflow_o | output | 1 | Sticky: a completion was dropped while full |

## Verification
The bench targets a posted write accepted in the same cycle as a completion. A design that snapshotted the count before that increment would release the completion one drain too early. It also drives the posted counters across their wrap point with three writes outstanding. A plain unsigned compare would then offer the head while posted data is still pending. A push while full, followed by draining all 256 entries, would expose a design that overwrote the oldest entry or let the dropped header surface. Toggling every configuration bit except bit 30 catches a bypass decoded from the wrong bit or from the whole word.

// File: rtl/cpl_ord_pkg.sv
package cpl_ord_pkg;

  localparam int unsigned CFG_W          = 32;
  localparam int unsigned CFG_BYPASS_BIT = 30;

  // Ordering gate bypass decoded from the configuration word.
  function automatic logic cfg_bypass(input logic [CFG_W-1:0] word);
    return word[CFG_BYPASS_BIT];
  endfunction

endpackage

// File: rtl/cpl_ord_posted_ctr.sv
module cpl_ord_posted_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             drain_i,
  output logic [CNT_W-1:0] arr_next_o,
  output logic [CNT_W-1:0] drn_cnt_o
);

  logic [CNT_W-1:0] arr_cnt;

  // Count including a write accepted this very cycle.
  assign arr_next_o = arr_cnt + CNT_W'(accept_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_cnt   <= '0;
      drn_cnt_o <= '0;
    end else begin
      arr_cnt <= arr_next_o;
      if (drain_i) drn_cnt_o <= drn_cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/cpl_ord_store.sv
module cpl_ord_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 56,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [OCC_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata_o = mem[rd_ptr];
  assign full_o  = (count_o == OCC_W'(DEPTH));
  assign empty_o = (count_o == '0);

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_i)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

endmodule

// File: rtl/cpl_ord_gate.sv
module cpl_ord_gate #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] drn_cnt_i,
  input  logic [CNT_W-1:0] head_mark_i,
  input  logic             bypass_i,
  output logic             open_o
);

  // Wrap-safe "drained has reached mark": sign of the modular difference.
  function automatic logic mark_reached(input logic [CNT_W-1:0] drained,
                                        input logic [CNT_W-1:0] mark);
    logic [CNT_W-1:0] diff;
    diff = drained - mark;
    return ~diff[CNT_W-1];
  endfunction

  assign open_o = bypass_i | mark_reached(drn_cnt_i, head_mark_i);

endmodule

// File: rtl/cpl_ord_fifo.sv
module cpl_ord_fifo
  import cpl_ord_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned BEATS_W = 8,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned OCC_W  = $clog2(DEPTH + 1),
  localparam int unsigned ENT_W  = HDR_W + BEATS_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpl_valid_i,
  input  logic [HDR_W-1:0]   cpl_hdr_i,
  input  logic [BEATS_W-1:0] cpl_beats_i,
  input  logic               pw_accept_i,
  input  logic               pw_drain_i,
  input  logic [CFG_W-1:0]   cfg_word_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [HDR_W-1:0]   out_hdr_o,
  output logic [BEATS_W-1:0] out_beats_o,
  output logic [OCC_W-1:0]   occupancy_o,
  output logic               full_o,
  output logic               overflow_o
);

  // Named internal events, also watched by the bound checker.
  logic             push_ok;
  logic             push_drop;
  logic             pop_fire;
  logic             gate_open;
  logic             empty;
  logic             bypass;
  logic [CNT_W-1:0] arr_next;
  logic [CNT_W-1:0] drn_cnt;
  logic [CNT_W-1:0] head_mark;
  logic [ENT_W-1:0] wdata;
  logic [ENT_W-1:0] rdata;
  logic             cfg_unused;

  assign bypass     = cfg_bypass(cfg_word_i);
  assign cfg_unused = ^{cfg_word_i[CFG_W-1:CFG_BYPASS_BIT+1],
                        cfg_word_i[CFG_BYPASS_BIT-1:0]};

  assign push_ok   = cpl_valid_i & ~full_o;
  assign push_drop = cpl_valid_i & full_o;
  assign pop_fire  = out_valid_o & out_ready_i;

  assign wdata = {cpl_hdr_i, cpl_beats_i, arr_next};
  assign {out_hdr_o, out_beats_o, head_mark} = rdata;

  assign out_valid_o = ~empty & gate_open;

  cpl_ord_posted_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (pw_accept_i),
    .drain_i    (pw_drain_i),
    .arr_next_o (arr_next),
    .drn_cnt_o  (drn_cnt)
  );

  cpl_ord_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_ok),
    .wdata_i (wdata),
    .pop_i   (pop_fire),
    .rdata_o (rdata),
    .count_o (occupancy_o),
    .full_o  (full_o),
    .empty_o (empty)
  );

  cpl_ord_gate #(.CNT_W(CNT_W)) u_gate (
    .drn_cnt_i   (drn_cnt),
    .head_mark_i (head_mark),
    .bypass_i    (bypass),
    .open_o      (gate_open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow_o <= 1'b0;
    else if (push_drop) overflow_o <= 1'b1;
  end

endmodule

// File: rtl/cpl_ord_fifo_chk.sv
module cpl_ord_fifo_chk #(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned HDR_W   = 32,
  parameter int unsigned BEATS_W = 8,
  parameter int unsigned OCC_W   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpl_valid_i,
  input logic               full_o,
  input logic               out_valid_o,
  input logic [HDR_W-1:0]   out_hdr_o,
  input logic [BEATS_W-1:0] out_beats_o,
  input logic [OCC_W-1:0]   occupancy_o,
  input logic               overflow_o,
  input logic               push_ok,
  input logic               pop_fire,
  input logic               gate_open
);

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy_o <= OCC_W'(DEPTH));

  // R6
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occupancy_o == $past(occupancy_o) + OCC_W'($past(push_ok))
                                               - OCC_W'($past(pop_fire)));

  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid_i && full_o) |=> overflow_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (gate_open && occupancy_o != '0));

  // R10
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy_o != '0 && !pop_fire) |=> ($stable(out_hdr_o) && $stable(out_beats_o)));

endmodule

bind cpl_ord_fifo cpl_ord_fifo_chk #(
  .DEPTH(DEPTH), .HDR_W(HDR_W), .BEATS_W(BEATS_W), .OCC_W(OCC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpl_valid_i (cpl_valid_i),
  .full_o      (full_o),
  .out_valid_o (out_valid_o),
  .out_hdr_o   (out_hdr_o),
  .out_beats_o (out_beats_o),
  .occupancy_o (occupancy_o),
  .overflow_o  (overflow_o),
  .push_ok     (push_ok),
  .pop_fire    (pop_fire),
  .gate_open   (gate_open)
);

// File: tb/sim_cpl_ord_fifo.sv
module sim_cpl_ord_fifo;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpl_valid_i;
  logic [31:0] cpl_hdr_i;
  logic [7:0]  cpl_beats_i;
  logic        pw_accept_i;
  logic        pw_drain_i;
  logic [31:0] cfg_word_i;
  logic        out_valid_o;
  logic        out_ready_i;
  logic [31:0] out_hdr_o;
  logic [7:0]  out_beats_o;
  logic [8:0]  occupancy_o;
  logic        full_o;
  logic        overflow_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cpl_ord_fifo u0 (.*);

  typedef struct packed {
    logic        cv;
    logic [31:0] hdr;
    logic [7:0]  beats;
    logic        acc;
    logic        drn;
    logic [31:0] cfg;
    logic        rdy;
    logic        e_valid;
    logic [31:0] e_hdr;
    logic [7:0]  e_beats;
    logic [8:0]  e_occ;
  } vec_t;

  // Expected outputs are those seen just after the edge that applies each row.
  localparam vec_t TBL [11] = '{
    '{1'b0, 32'h0,  8'd0, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,  8'd0, 9'd0},
    '{1'b1, 32'hA1, 8'd3, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,  8'd0, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 32'h0,  8'd0, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1, 32'hA1, 8'd3, 9'd1},
    '{1'b1, 32'hA2, 8'd5, 1'b1, 1'b0, 32'h0,        1'b0, 1'b1, 32'hA1, 8'd3, 9'd2},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,  8'd0, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b0, 32'h0,  8'd0, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b1, 32'hA2, 8'd5, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b0, 32'hBFFFFFFF, 1'b0, 1'b0, 32'h0,  8'd0, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b1, 32'hA2, 8'd5, 9'd1},
    '{1'b0, 32'h0,  8'd0, 1'b0, 1'b0, 32'h0,        1'b1, 1'b0, 32'h0,  8'd0, 9'd0}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic cv, input logic [31:0] h, input logic [7:0] b,
                       input logic a, input logic d, input logic [31:0] cfg,
                       input logic r);
    cpl_valid_i = cv; cpl_hdr_i = h; cpl_beats_i = b;
    pw_accept_i = a; pw_drain_i = d; cfg_word_i = cfg; out_ready_i = r;
  endtask

  task automatic step(input logic cv, input logic [31:0] h, input logic [7:0] b,
                      input logic a, input logic d, input logic [31:0] cfg,
                      input logic r);
    @(negedge clk);
    drive(cv, h, b, a, d, cfg, r);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b0);
    do_reset();
    #1;
    // R1 reset state
    chk(occupancy_o == 0, "R1 occupancy", 32'(occupancy_o), 0);
    chk(!full_o && !overflow_o && !out_valid_o, "R1 flags",
        {29'd0, full_o, overflow_o, out_valid_o}, 0);

    // Table walk: R3 gate, R4 later posted, R5 bypass bit, R10 head stable on push
    foreach (TBL[i]) begin
      step(TBL[i].cv, TBL[i].hdr, TBL[i].beats, TBL[i].acc, TBL[i].drn,
           TBL[i].cfg, TBL[i].rdy);
      chk(out_valid_o == TBL[i].e_valid, "R3/R4/R5 valid", 32'(out_valid_o),
          32'(TBL[i].e_valid));
      chk(occupancy_o == TBL[i].e_occ, "R6 occupancy", 32'(occupancy_o),
          32'(TBL[i].e_occ));
      if (TBL[i].e_valid) begin
        chk(out_hdr_o == TBL[i].e_hdr, "R2/R10 header", out_hdr_o, TBL[i].e_hdr);
        chk(out_beats_o == TBL[i].e_beats, "R2 beats", 32'(out_beats_o),
            32'(TBL[i].e_beats));
      end
    end

    // R8: head gated, later entry waits behind it
    step(1'b1, 32'hD1, 8'd1, 1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b1, 32'hD2, 8'd2, 1'b0, 1'b0, 32'h0, 1'b0);
    chk(!out_valid_o && occupancy_o == 2, "R8 both held", 32'(occupancy_o), 2);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk(out_valid_o && out_hdr_o == 32'hD1, "R8 head first", out_hdr_o, 32'hD1);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b1);
    chk(out_valid_o && out_hdr_o == 32'hD2, "R8 second next", out_hdr_o, 32'hD2);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b1);
    chk(occupancy_o == 0, "R8 drained", 32'(occupancy_o), 0);

    // R6/R7: fill, overflow, drain in order
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 32'(i) + 32'h100, 8'(i), 1'b0, 1'b0, 32'h0, 1'b0);
    chk(occupancy_o == DEPTH && full_o, "R6 full", 32'(occupancy_o), DEPTH);
    chk(!overflow_o, "R7 no overflow yet", 32'(overflow_o), 0);
    step(1'b1, 32'hDEAD, 8'd9, 1'b0, 1'b0, 32'h0, 1'b1);
    chk(overflow_o, "R7 overflow set", 32'(overflow_o), 1);
    chk(occupancy_o == DEPTH - 1, "R7 dropped push", 32'(occupancy_o), DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) begin
      chk(out_valid_o && out_hdr_o == 32'(i) + 32'h100, "R2/R7 order",
          out_hdr_o, 32'(i) + 32'h100);
      step(1'b0, 32'h0, 8'd0, 1'b0, 1'b0, 32'h0, 1'b1);
    end
    chk(occupancy_o == 0 && !out_valid_o, "R7 no dropped entry",
        32'(occupancy_o), 0);
    chk(overflow_o, "R7 sticky", 32'(overflow_o), 1);
    do_reset();
    #1;
    chk(!overflow_o, "R1 overflow cleared", 32'(overflow_o), 0);

    // R9: counters wrap with three posted writes outstanding
    for (int i = 0; i < 65534; i++) begin
      @(negedge clk);
      drive(1'b0, 32'h0, 8'd0, 1'b1, 1'b1, 32'h0, 1'b0);
    end
    step(1'b0, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b0, 32'h0, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b1, 32'hE1, 8'd4, 1'b1, 1'b0, 32'h0, 1'b0);
    chk(!out_valid_o, "R9 held across wrap", 32'(out_valid_o), 0);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b1, 32'h0, 1'b0);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk(!out_valid_o, "R9 one still pending", 32'(out_valid_o), 0);
    step(1'b0, 32'h0, 8'd0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk(out_valid_o && out_hdr_o == 32'hE1, "R9 released", out_hdr_o, 32'hE1);

    finish_run();
  end

endmodule